// File: doc/BRIEF.md
# Parallel Flash Bus Operation Decoder

This block sits between the asynchronous host pins of a parallel NOR-style flash and its synchronous internals. It resamples the active-low chip enable, output enable, write enable and hardware reset pins, together with a word/byte select pin, the address pins and the data pins, through a short synchronizer chain. Each sampled cycle is then classified as a read, write, standby, output-disable or reset cycle. The external 16-bit data bus is modelled as separate input, output and per-lane output-enable vectors, so no internal tri-state logic is needed.

Read cycles send a read request and a word address to a backing array with a one-cycle synchronous read. The returned word is formatted onto the bus: all lanes in word mode, or one byte on the low lanes in byte mode. In byte mode the top data pin acts as the extra low address bit that picks the byte. Write cycles are captured as a whole. When write enable or chip enable ends the cycle, one strobe cycle hands the latched address and data to the command logic. The block comes up in read-array mode after its own reset or a hardware reset, so a read returns array data with no prior command. A captured write hands the read path to the data supplied by the command sequencer, until that sequencer requests read-array mode again.

Top module: `flash_bus_decoder`

## Requirements
- R1: `bus_op` gives the class of the pin levels sampled SYNC_STAGES edges earlier (the sampling edge counts as edge 0). Encoding: 0 reset, 1 standby, 2 output disable, 3 read, 4 write. Priority: hardware reset low gives reset; otherwise chip enable high gives standby; otherwise write enable low with output enable high gives write; otherwise output enable low with write enable high gives read; any other level pattern gives output disable.
- R2: In word mode (`pin_word` high), a read drives all 16 lanes (`dq_oe` = 16'hFFFF) with the selected word, SYNC_STAGES+2 edges after sampling.
- R3: In byte mode (`pin_word` low), a read drives only lanes 0 to 7 (`dq_oe` = 16'h00FF). `dq_out[15:8]` is zero. The low byte carries word bits 7:0 when `dq_in[15]` was sampled 0, and bits 15:8 when it was sampled 1.
- R4: In any cycle that is not a read, `dq_oe` and `dq_out` are both zero.
- R5: While the hardware reset pin is low, all other pins are ignored: no lane is driven, no read request is made and no write strobe is given. A write that is cut off by the reset pin produces no strobe.
- R6: `cmd_wr` pulses for one cycle, SYNC_STAGES edges after the first sample where a write cycle has ended, provided that sample is not a reset cycle. It does not matter whether the write ended through write enable or chip enable. `cmd_addr` carries the address from the last write sample.
- R7: With the strobe, `cmd_byte` and `cmd_lsb` report byte mode and the sampled `dq_in[15]`. `cmd_lsb` is 0 in word mode. `cmd_data` is `dq_in` in word mode, or {8'h00, `dq_in[7:0]`} in byte mode.
- R8: Read data comes from `arr_rdata` while in read-array mode, and from `sm_rdata` otherwise. Read-array mode is entered at reset, on a sampled reset cycle and on `sm_read_array`. It is left on the cycle after a `cmd_wr` strobe. A reset cycle takes priority over the strobe, and the strobe takes priority over `sm_read_array`.
- R9: While `rst` is high, all outputs are zero except `bus_op`, which reads 1 (standby).
- R10: `arr_rd` is high, with `arr_addr` equal to the sampled address, in exactly the cycles where `bus_op` shows a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_ce_n | input | 1 | Chip enable pin, active low |
| pin_oe_n | input | 1 | Output enable pin, active low |
| pin_we_n | input | 1 | Write enable pin, active low |
| pin_reset_n | input | 1 | Hardware reset pin, active low |
| pin_word | input | 1 | High for word mode, low for byte mode |
| pin_addr | input | AW | Word address pins |
| dq_in | input | DQ_W | Data pins as seen at the input |
| dq_out | output | DQ_W | Data driven onto the pins |
| dq_oe | output | DQ_W | Per-lane output enable |
| bus_op | output | 3 | Class of the sampled cycle |
| arr_addr | output | AW | Array word address |
| arr_rd | output | 1 | Array read request |
| arr_rdata | input | DQ_W | Array word, valid one cycle after request |
| sm_rdata | input | DQ_W | Status or identifier word from the sequencer |
| sm_read_array | input | 1 | Sequencer request to return to read-array mode |
| cmd_wr | output | 1 | One-cycle write strobe |
| cmd_addr | output | AW | Latched write address |
| cmd_data | output | DQ_W | Latched write data |
| cmd_lsb | output | 1 | Latched byte address bit |
| cmd_byte | output | 1 | Write was made in byte mode |

## Verification
The reference model is driven with held pin patterns of every class, including the conflicting output-enable/write-enable pattern. It also sees word reads at several addresses and byte reads with the low address bit at both values, which shows whether the lane and byte choices are right. Writes are ended once by write enable and once by chip enable, and back-to-back one-cycle writes check that each strobe comes out single and in its own place. A write cut off by the reset pin, and a read under reset, separate true reset priority from mere classification. Reads after a write, after the sequencer request and after a hardware reset check that the data source moves between array and sequencer at the right moments.

// File: rtl/flash_bus_pkg.sv
`timescale 1ns/1ps
package flash_bus_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_OUTDIS  = 3'd2,
    OP_READ    = 3'd3,
    OP_WRITE   = 3'd4
  } bus_op_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic hrst_n;
    logic word;
  } ctrl_s;

  localparam int CTRL_W = 5;
  localparam ctrl_s CTRL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, hrst_n: 1'b1, word: 1'b1};

  function automatic bus_op_e classify(ctrl_s c);
    if (!c.hrst_n)                return OP_RESET;
    else if (c.ce_n)              return OP_STANDBY;
    else if (!c.we_n && c.oe_n)   return OP_WRITE;
    else if (!c.oe_n && c.we_n)   return OP_READ;
    else                          return OP_OUTDIS;
  endfunction

endpackage

// File: rtl/fbd_pin_sync.sv
`timescale 1ns/1ps
module fbd_pin_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[LAST];
endmodule

// File: rtl/fbd_op_decode.sv
`timescale 1ns/1ps
module fbd_op_decode
  import flash_bus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ctrl_s   s_ctrl,
  output bus_op_e op_now,
  output bus_op_e op_q
);
  assign op_now = classify(s_ctrl);

  always_ff @(posedge clk) begin
    if (rst) op_q <= OP_STANDBY;
    else     op_q <= op_now;
  end

  // R5: a low reset pin sample always becomes a reset cycle
  p_reset_dominates_r5: assert property (@(posedge clk) disable iff (rst)
    !s_ctrl.hrst_n |=> op_q == OP_RESET);

  // R1: a chip enable high sample with reset high is standby
  p_standby_class_r1: assert property (@(posedge clk) disable iff (rst)
    (s_ctrl.ce_n && s_ctrl.hrst_n) |=> op_q == OP_STANDBY);
endmodule

// File: rtl/fbd_write_capture.sv
`timescale 1ns/1ps
module fbd_write_capture
  import flash_bus_pkg::*;
#(
  parameter int AW = 21,
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  bus_op_e         op_now,
  input  logic [AW-1:0]   s_addr,
  input  logic [DQ_W-1:0] s_dq,
  input  logic            s_word,
  output logic            cmd_wr,
  output logic [AW-1:0]   cmd_addr,
  output logic [DQ_W-1:0] cmd_data,
  output logic            cmd_lsb,
  output logic            cmd_byte
);
  localparam int HALF = DQ_W / 2;

  logic            wr_prev_q;
  logic [AW-1:0]   lat_addr;
  logic [DQ_W-1:0] lat_data;
  logic            lat_lsb;
  logic            lat_byte;
  logic            wr_end;
  logic [DQ_W-1:0] fmt_data;

  assign wr_end   = wr_prev_q && (op_now != OP_WRITE) && (op_now != OP_RESET);
  assign fmt_data = s_word ? s_dq : {{(DQ_W-HALF){1'b0}}, s_dq[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev_q <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= '0;
      lat_lsb   <= 1'b0;
      lat_byte  <= 1'b0;
    end else begin
      wr_prev_q <= (op_now == OP_WRITE);
      if (op_now == OP_WRITE) begin
        lat_addr <= s_addr;
        lat_data <= fmt_data;
        lat_lsb  <= !s_word && s_dq[DQ_W-1];
        lat_byte <= !s_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_wr   <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
      cmd_lsb  <= 1'b0;
      cmd_byte <= 1'b0;
    end else begin
      cmd_wr <= wr_end;
      if (wr_end) begin
        cmd_addr <= lat_addr;
        cmd_data <= lat_data;
        cmd_lsb  <= lat_lsb;
        cmd_byte <= lat_byte;
      end
    end
  end

  // R6: strobe lasts exactly one cycle
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> !cmd_wr);

  // R6: a strobe is always preceded by a write sample
  p_strobe_after_write_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |-> $past(wr_prev_q));

  // R7: the byte-lane address bit is only reported for byte writes
  p_lsb_only_byte_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_lsb) |-> cmd_byte);
endmodule

// File: rtl/fbd_read_path.sv
`timescale 1ns/1ps
module fbd_read_path
  import flash_bus_pkg::*;
#(
  parameter int AW = 21,
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  bus_op_e         op_now,
  input  logic [AW-1:0]   s_addr,
  input  logic            s_word,
  input  logic            s_lsb,
  input  logic            read_array,
  input  logic [DQ_W-1:0] arr_rdata,
  input  logic [DQ_W-1:0] sm_rdata,
  output logic [AW-1:0]   arr_addr,
  output logic            arr_rd,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] dq_oe
);
  localparam int HALF = DQ_W / 2;
  localparam logic [DQ_W-1:0] MASK_ALL  = '1;
  localparam logic [DQ_W-1:0] MASK_LOW  = {{(DQ_W-HALF){1'b0}}, {HALF{1'b1}}};

  logic byte1_q, lsb1_q;
  logic rd2_q, byte2_q, lsb2_q, rsel2_q;
  logic [DQ_W-1:0] word_sel;
  logic [HALF-1:0] lane_sel;

  // stage 1: request to the array
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_addr <= '0;
      arr_rd   <= 1'b0;
      byte1_q  <= 1'b0;
      lsb1_q   <= 1'b0;
    end else begin
      arr_addr <= s_addr;
      arr_rd   <= (op_now == OP_READ);
      byte1_q  <= !s_word;
      lsb1_q   <= s_lsb;
    end
  end

  // stage 2: align with the array's registered read
  always_ff @(posedge clk) begin
    if (rst) begin
      rd2_q   <= 1'b0;
      byte2_q <= 1'b0;
      lsb2_q  <= 1'b0;
      rsel2_q <= 1'b1;
    end else begin
      rd2_q   <= arr_rd;
      byte2_q <= byte1_q;
      lsb2_q  <= lsb1_q;
      rsel2_q <= read_array;
    end
  end

  assign word_sel = rsel2_q ? arr_rdata : sm_rdata;
  assign lane_sel = lsb2_q ? word_sel[DQ_W-1:HALF] : word_sel[HALF-1:0];

  // stage 3: registered bus drive
  always_ff @(posedge clk) begin
    if (rst || !rd2_q) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (byte2_q) begin
      dq_out <= {{(DQ_W-HALF){1'b0}}, lane_sel};
      dq_oe  <= MASK_LOW;
    end else begin
      dq_out <= word_sel;
      dq_oe  <= MASK_ALL;
    end
  end

  // R4: lanes are driven only when a read reached stage 2
  p_drive_needs_read_r4: assert property (@(posedge clk) disable iff (rst)
    (dq_oe != '0) |-> $past(rd2_q));

  // R2: only the whole bus, the low half or nothing is enabled
  p_oe_pattern_r2: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == '0) || (dq_oe == MASK_ALL) || (dq_oe == MASK_LOW));

  // R3: the low-half pattern comes from a byte-mode sample
  p_low_half_is_byte_r3: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == MASK_LOW) |-> $past(byte2_q));
endmodule

// File: rtl/flash_bus_decoder.sv
`timescale 1ns/1ps
module flash_bus_decoder
  import flash_bus_pkg::*;
#(
  parameter int AW = 21,
  parameter int DQ_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pin_ce_n,
  input  logic            pin_oe_n,
  input  logic            pin_we_n,
  input  logic            pin_reset_n,
  input  logic            pin_word,
  input  logic [AW-1:0]   pin_addr,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] dq_oe,
  output logic [2:0]      bus_op,
  output logic [AW-1:0]   arr_addr,
  output logic            arr_rd,
  input  logic [DQ_W-1:0] arr_rdata,
  input  logic [DQ_W-1:0] sm_rdata,
  input  logic            sm_read_array,
  output logic            cmd_wr,
  output logic [AW-1:0]   cmd_addr,
  output logic [DQ_W-1:0] cmd_data,
  output logic            cmd_lsb,
  output logic            cmd_byte
);
  localparam int PIN_W = CTRL_W + AW + DQ_W;
  localparam logic [PIN_W-1:0] PIN_IDLE = {CTRL_IDLE, {AW{1'b0}}, {DQ_W{1'b0}}};

  ctrl_s           raw_ctrl, s_ctrl;
  logic [PIN_W-1:0] raw_pins, s_pins;
  logic [AW-1:0]   s_addr;
  logic [DQ_W-1:0] s_dq;
  bus_op_e         op_now, op_q;
  logic            read_array_q;

  assign raw_ctrl = '{ce_n: pin_ce_n, oe_n: pin_oe_n, we_n: pin_we_n,
                      hrst_n: pin_reset_n, word: pin_word};
  assign raw_pins = {raw_ctrl, pin_addr, dq_in};

  fbd_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
    .clk (clk), .rst (rst), .d (raw_pins), .q (s_pins)
  );

  assign s_ctrl = s_pins[PIN_W-1 -: CTRL_W];
  assign s_addr = s_pins[DQ_W +: AW];
  assign s_dq   = s_pins[DQ_W-1:0];

  fbd_op_decode i_dec (
    .clk (clk), .rst (rst), .s_ctrl (s_ctrl), .op_now (op_now), .op_q (op_q)
  );

  assign bus_op = op_q;

  fbd_write_capture #(.AW(AW), .DQ_W(DQ_W)) i_wcap (
    .clk (clk), .rst (rst), .op_now (op_now), .s_addr (s_addr), .s_dq (s_dq),
    .s_word (s_ctrl.word), .cmd_wr (cmd_wr), .cmd_addr (cmd_addr),
    .cmd_data (cmd_data), .cmd_lsb (cmd_lsb), .cmd_byte (cmd_byte)
  );

  // read-array mode: reset cycle > command strobe > sequencer request
  always_ff @(posedge clk) begin
    if (rst)                        read_array_q <= 1'b1;
    else if (op_now == OP_RESET)    read_array_q <= 1'b1;
    else if (cmd_wr)                read_array_q <= 1'b0;
    else if (sm_read_array)         read_array_q <= 1'b1;
  end

  fbd_read_path #(.AW(AW), .DQ_W(DQ_W)) i_rd (
    .clk (clk), .rst (rst), .op_now (op_now), .s_addr (s_addr),
    .s_word (s_ctrl.word), .s_lsb (s_dq[DQ_W-1]), .read_array (read_array_q),
    .arr_rdata (arr_rdata), .sm_rdata (sm_rdata), .arr_addr (arr_addr),
    .arr_rd (arr_rd), .dq_out (dq_out), .dq_oe (dq_oe)
  );

  // R8: mode is only entered through reset, a reset cycle or the sequencer
  p_mode_set_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(read_array_q) |-> $past(rst || op_now == OP_RESET || sm_read_array));

  // R8: a strobe leaves read-array mode unless a reset cycle intervenes
  p_mode_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && op_now != OP_RESET) |=> !read_array_q);

  // R10: array request matches the reported read class
  p_req_matches_op_r10: assert property (@(posedge clk) disable iff (rst)
    arr_rd == (bus_op == 3'd3));
endmodule

// File: tb/test_flash_bus_decoder.sv
`timescale 1ns/1ps
module test_flash_bus_decoder;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int SY = 2;

  typedef struct packed {
    logic ce_n, oe_n, we_n, hr_n, word;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq;
  } pin_t;

  localparam pin_t IDLE = '{ce_n:1'b1, oe_n:1'b1, we_n:1'b1, hr_n:1'b1, word:1'b1,
                           addr:'0, dq:'0};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  pin_t pins;
  logic [DW-1:0] arr_rdata, sm_rdata;
  logic sm_read_array;
  logic [DW-1:0] dq_out, dq_oe, cmd_data;
  logic [2:0] bus_op;
  logic [AW-1:0] arr_addr, cmd_addr;
  logic arr_rd, cmd_wr, cmd_lsb, cmd_byte;

  flash_bus_decoder #(.AW(AW), .DQ_W(DW), .SYNC_STAGES(SY)) i_flash_bus_decoder (
    .clk(clk), .rst(rst), .pin_ce_n(pins.ce_n), .pin_oe_n(pins.oe_n),
    .pin_we_n(pins.we_n), .pin_reset_n(pins.hr_n), .pin_word(pins.word),
    .pin_addr(pins.addr), .dq_in(pins.dq), .dq_out(dq_out), .dq_oe(dq_oe),
    .bus_op(bus_op), .arr_addr(arr_addr), .arr_rd(arr_rd), .arr_rdata(arr_rdata),
    .sm_rdata(sm_rdata), .sm_read_array(sm_read_array), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_lsb(cmd_lsb), .cmd_byte(cmd_byte)
  );

  function automatic logic [DW-1:0] arr_fn(logic [AW-1:0] a);
    return (a[15:0] * 16'd40503) ^ 16'h5A5A ^ {11'b0, a[20:16]};
  endfunction

  // backing array: one-cycle synchronous read
  always @(posedge clk) arr_rdata <= arr_fn(arr_addr);

  function automatic int dec(pin_t p);
    if (!p.hr_n) return 0;
    if (p.ce_n) return 1;
    if (!p.we_n && p.oe_n) return 4;
    if (!p.oe_n && p.we_n) return 3;
    return 2;
  endfunction

  int nchk = 0, nerr = 0, cyc = 0;
  bit checking = 1'b0;
  pin_t hist [16];
  logic [DW-1:0] smd_h [16];
  bit mode_h [16];
  bit stb_h [16];

  initial begin
    for (int i = 0; i < 16; i++) begin
      hist[i] = IDLE; smd_h[i] = '0; mode_h[i] = 1'b1; stb_h[i] = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference model state, advanced on every edge
  always @(posedge clk) begin
    int i, o0, o1;
    cyc++;
    i = cyc & 15;
    smd_h[i] = sm_rdata;
    if (rst) begin
      hist[i] = IDLE; mode_h[i] = 1'b1; stb_h[i] = 1'b0;
    end else begin
      hist[i] = pins;
      o0 = dec(hist[(cyc - SY) & 15]);
      o1 = dec(hist[(cyc - SY - 1) & 15]);
      stb_h[i] = (o1 == 4) && (o0 != 4) && (o0 != 0);
      if (o0 == 0)                  mode_h[i] = 1'b1;
      else if (stb_h[(cyc-1) & 15]) mode_h[i] = 1'b0;
      else if (sm_read_array)       mode_h[i] = 1'b1;
      else                          mode_h[i] = mode_h[(cyc-1) & 15];
    end
    if (cyc > 20000) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // compare outputs away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      pin_t p0, p1, p2;
      int o0, o2;
      bit md;
      string t;
      logic [DW-1:0] w, eo, ee;
      p0 = hist[(cyc - SY) & 15];
      p1 = hist[(cyc - SY - 1) & 15];
      p2 = hist[(cyc - SY - 2) & 15];
      o0 = dec(p0);
      o2 = dec(p2);
      chk(bus_op == o0[2:0], (o0 == 0) ? "R5" : "R1", "bus_op", 32'(bus_op), 32'(o0));
      chk(arr_rd == (o0 == 3), "R10", "arr_rd", 32'(arr_rd), 32'(o0 == 3));
      if (o0 == 3) chk(arr_addr == p0.addr, "R10", "arr_addr", 32'(arr_addr), 32'(p0.addr));
      chk(cmd_wr == stb_h[cyc & 15], (o0 == 0) ? "R5" : "R6", "cmd_wr",
          32'(cmd_wr), 32'(stb_h[cyc & 15]));
      if (stb_h[cyc & 15] && cmd_wr) begin
        chk(cmd_addr == p1.addr, "R6", "cmd_addr", 32'(cmd_addr), 32'(p1.addr));
        ee = p1.word ? p1.dq : {8'h00, p1.dq[7:0]};
        chk(cmd_data == ee, "R7", "cmd_data", 32'(cmd_data), 32'(ee));
        chk(cmd_byte == !p1.word, "R7", "cmd_byte", 32'(cmd_byte), 32'(!p1.word));
        chk(cmd_lsb == (!p1.word && p1.dq[15]), "R7", "cmd_lsb",
            32'(cmd_lsb), 32'(!p1.word && p1.dq[15]));
      end
      md = mode_h[(cyc - 2) & 15];
      w  = md ? arr_fn(p2.addr) : smd_h[cyc & 15];
      if (o2 != 3)       begin eo = '0;       ee = '0; end
      else if (!p2.word) begin eo = 16'h00FF; ee = {8'h00, p2.dq[15] ? w[15:8] : w[7:0]}; end
      else               begin eo = 16'hFFFF; ee = w; end
      if (o2 == 0)       t = "R5";
      else if (o2 != 3)  t = "R4";
      else if (!p2.word) t = "R3";
      else if (!md)      t = "R8";
      else               t = "R2";
      chk(dq_oe == eo, t, "dq_oe", 32'(dq_oe), 32'(eo));
      chk(dq_out == ee, t, "dq_out", 32'(dq_out), 32'(ee));
    end
  end

  task automatic drive(input logic ce_n, oe_n, we_n, hr_n, word,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input int hold);
    pins = '{ce_n:ce_n, oe_n:oe_n, we_n:we_n, hr_n:hr_n, word:word, addr:a, dq:d};
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    pins = IDLE;
    sm_rdata = 16'hC0DE;
    sm_read_array = 1'b0;
    repeat (6) @(negedge clk);
    // R9: reset state
    chk(bus_op == 3'd1, "R9", "bus_op in reset", 32'(bus_op), 32'd1);
    chk(dq_oe == '0 && dq_out == '0, "R9", "bus drive in reset", 32'(dq_oe), 32'd0);
    chk(!cmd_wr && !arr_rd, "R9", "strobes in reset", 32'({cmd_wr, arr_rd}), 32'd0);
    rst = 1'b0;
    checking = 1'b1;
    @(negedge clk);

    // word reads straight after reset (R2, R8, R10)
    drive(0, 0, 1, 1, 1, 21'h00123, 16'h0, 4);
    drive(0, 0, 1, 1, 1, 21'h1ABCD, 16'h0, 3);
    drive(0, 0, 1, 1, 1, 21'h0FFFF, 16'h0, 5);
    // output disable, standby, conflicting enables (R1, R4)
    drive(0, 1, 1, 1, 1, 21'h00010, 16'h0, 4);
    drive(1, 0, 1, 1, 1, 21'h00011, 16'h0, 4);
    drive(0, 0, 0, 1, 1, 21'h00012, 16'h1234, 4);
    // byte reads, both byte lanes (R3)
    drive(0, 0, 1, 1, 0, 21'h00456, 16'h0000, 4);
    drive(0, 0, 1, 1, 0, 21'h00456, 16'h8000, 4);
    drive(0, 0, 1, 1, 0, 21'h1F001, 16'h8000, 3);
    drive(1, 1, 1, 1, 1, 21'h0, 16'h0, 4);

    // word write ended by write enable (R6), then read gives sequencer data (R8)
    drive(0, 1, 0, 1, 1, 21'h00555, 16'hA5F0, 3);
    drive(0, 1, 1, 1, 1, 21'h00555, 16'hA5F0, 3);
    drive(0, 0, 1, 1, 1, 21'h00200, 16'h0, 5);
    sm_rdata = 16'h0080;
    drive(0, 0, 1, 1, 0, 21'h00200, 16'h8000, 4);
    sm_read_array = 1'b1;
    @(negedge clk);
    sm_read_array = 1'b0;
    drive(0, 0, 1, 1, 1, 21'h00201, 16'h0, 5);

    // byte write ended by chip enable (R7)
    drive(0, 1, 0, 1, 0, 21'h002AA, 16'h803C, 3);
    drive(1, 1, 0, 1, 0, 21'h002AA, 16'h803C, 3);
    drive(1, 1, 1, 1, 1, 21'h0, 16'h0, 2);
    // back-to-back single-cycle writes (R6)
    for (int k = 0; k < 4; k++) begin
      drive(0, 1, 0, 1, 1, 21'(k * 3 + 1), 16'(16'h1111 * (k + 1)), 1);
      drive(0, 1, 1, 1, 1, 21'(k * 3 + 1), 16'h0, 1);
    end
    drive(0, 0, 1, 1, 1, 21'h00300, 16'h0, 4);

    // write cut off by the reset pin: no strobe (R5)
    drive(0, 1, 0, 1, 1, 21'h00777, 16'hBEEF, 3);
    drive(0, 1, 0, 0, 1, 21'h00777, 16'hBEEF, 3);
    drive(1, 1, 1, 0, 1, 21'h00777, 16'hBEEF, 3);
    // read attempted under reset: no drive (R5)
    drive(0, 0, 1, 0, 1, 21'h00400, 16'h0, 4);
    // reset pin released: read-array mode restored (R8)
    drive(0, 0, 1, 1, 1, 21'h00400, 16'h0, 5);
    // write, then reset pulse, then read returns array (R8)
    drive(0, 1, 0, 1, 1, 21'h00AAA, 16'h0055, 2);
    drive(0, 1, 1, 1, 1, 21'h00AAA, 16'h0055, 2);
    drive(0, 0, 1, 1, 1, 21'h00401, 16'h0, 4);
    drive(1, 1, 1, 0, 1, 21'h0, 16'h0, 2);
    drive(0, 0, 1, 1, 1, 21'h00402, 16'h0, 5);
    drive(1, 1, 1, 1, 1, 21'h0, 16'h0, 6);

    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule